// File: doc/BRIEF.md
# Power-Down and Wakeup Sequencer

This block governs the low-power state of a small microcontroller subsystem. Firmware asks for power-down by writing a 1 to the power-down bit of its power-control register. The sequencer then takes away the core clock enable and switches off the oscillator and PLL enables. While asleep it runs from a free-running low-speed clock. It watches three wake sources: bus activity, a primary wake pin and a secondary wake pin. The secondary pin can instead serve as a general-purpose I/O.

When an enabled source becomes active, the sequencer turns the oscillator and PLL back on. It then waits for a programmable settle count followed by a PLL-lock indication. Only after that does it restore the core clock, and it raises a single-cycle wakeup interrupt in the same cycle. A sticky status field records which sources caused the wake. Firmware clears it bit by bit by writing ones.

Top module: `pdwake_ctrl`

## Requirements
- R1: After synchronous reset, osc_en, pll_en and clk_en are 1, wake_irq is 0 and wake_stat is 0.
- R2: While running, a cycle with pctl_we=1 and pctl_pd_bit=1 makes osc_en, pll_en and clk_en 0 at the next clock edge. A write with pctl_pd_bit=0 changes nothing.
- R3: While asleep, an enabled active wake input goes through a two-flop synchroniser. osc_en and pll_en return to 1 on the third clock edge after the input changes, and clk_en stays 0 at that point.
- R4: clk_en returns to 1 only after settle_cfg clock edges have passed since the oscillator restart and pll_lock has been seen high. With lock already high this is the (settle_cfg+1)-th edge after the restart. If lock is low, clk_en waits for it.
- R5: wake_irq is a single-cycle pulse that is raised on the same edge where clk_en returns to 1.
- R6: Source index mapping is bit 0 = bus activity (active high), bit 1 = primary pin, bit 2 = secondary pin. For each pin, polarity bit 0 means active low (the default) and 1 means active high.
- R7: With cfg_b_gpio=1 the secondary pin never wakes the block, whatever its level.
- R8: A source whose bit in cfg_en is 0 never wakes the block.
- R9: On the wake edge, wake_stat gains a 1 for each enabled source active at that edge. Each bit stays set until a cycle with the matching stat_clr bit at 1 clears it.
- R10: Wake inputs asserted while the block is running change neither the clock enables nor wake_stat.
- R11: Bus activity alone, when enabled, wakes the block. No link-connected state is involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running low-speed clock |
| rst | input | 1 | Synchronous active-high reset |
| pctl_we | input | 1 | Power-control register write strobe |
| pctl_pd_bit | input | 1 | Written value of the power-down bit (bit 0) |
| wk_pin_a | input | 1 | Primary wake pin, asynchronous |
| wk_pin_b | input | 1 | Secondary wake pin / GPIO, asynchronous |
| bus_act | input | 1 | Bus-activity indication, asynchronous, active high |
| pll_lock | input | 1 | PLL lock indication |
| cfg_pol_a | input | 1 | Primary pin polarity (0 active low) |
| cfg_pol_b | input | 1 | Secondary pin polarity (0 active low) |
| cfg_b_gpio | input | 1 | Secondary pin used as GPIO, no wake |
| cfg_en | input | 3 | Per-source wake enables (bit 0 bus, 1 pin A, 2 pin B) |
| settle_cfg | input | 8 | PLL settle count in clock cycles |
| stat_clr | input | 3 | Write-1-to-clear strobes for wake_stat |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL enable |
| clk_en | output | 1 | Core clock enable |
| wake_irq | output | 1 | Wakeup interrupt pulse |
| wake_stat | output | 3 | Sticky wake-cause bits |

## Verification
The bench goes after the points where a sequencer is most easily wrong. It checks the exact restart edge after the synchroniser: a design with one flop too few or too many moves osc_en a cycle early or late. It checks the exact edge where the clock returns after the settle count, including a zero count and a held-low lock; an off-by-one counter, or one that ignores lock, returns clk_en too soon. Pin polarity, GPIO masking and per-source enables are swept across a vector table. A wrong XOR sense or a missing mask would wake on the idle level, or on a source that should be silent. Wake inputs driven while running, and status clearing, are tested so that a status register that sets outside the wake edge, or that never clears, shows up.

// File: rtl/pdw_pkg.sv
package pdw_pkg;
  localparam int NSRC    = 3;
  localparam int SRC_BUS = 0;
  localparam int SRC_A   = 1;
  localparam int SRC_B   = 2;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_WARM  = 2'd2
  } pd_state_t;
endpackage

// File: rtl/pdw_sync.sv
module pdw_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= '0;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pdw_wake_detect.sv
module pdw_wake_detect
  import pdw_pkg::*;
(
  input  logic [NSRC-1:0] lvl,
  input  logic [NSRC-1:0] pol,
  input  logic [NSRC-1:0] en,
  input  logic            b_gpio,
  output logic [NSRC-1:0] hit
);
  logic [NSRC-1:0] mask;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (i == SRC_B) begin : g_gpio_capable
      assign mask[i] = en[i] & ~b_gpio;
    end else begin : g_plain
      assign mask[i] = en[i];
    end
    assign hit[i] = mask[i] & ~(lvl[i] ^ pol[i]);
  end
endmodule

// File: rtl/pdw_settle.sv
module pdw_settle #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                 cnt <= '0;
    else if (load)           cnt <= load_val;
    else if (run && cnt != 0) cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/pdwake_ctrl.sv
module pdwake_ctrl
  import pdw_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pctl_we,
  input  logic             pctl_pd_bit,
  input  logic             wk_pin_a,
  input  logic             wk_pin_b,
  input  logic             bus_act,
  input  logic             pll_lock,
  input  logic             cfg_pol_a,
  input  logic             cfg_pol_b,
  input  logic             cfg_b_gpio,
  input  logic [2:0]       cfg_en,
  input  logic [CNT_W-1:0] settle_cfg,
  input  logic [2:0]       stat_clr,
  output logic             osc_en,
  output logic             pll_en,
  output logic             clk_en,
  output logic             wake_irq,
  output logic [2:0]       wake_stat
);
  pd_state_t       state, nxt;
  logic [NSRC-1:0] raw, lvl, pol, hit;
  logic            settle_done, start_warm;

  assign raw[SRC_BUS] = bus_act;
  assign raw[SRC_A]   = wk_pin_a;
  assign raw[SRC_B]   = wk_pin_b;
  assign pol[SRC_BUS] = 1'b1;
  assign pol[SRC_A]   = cfg_pol_a;
  assign pol[SRC_B]   = cfg_pol_b;

  pdw_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(lvl)
  );

  pdw_wake_detect u_det (
    .lvl(lvl), .pol(pol), .en(cfg_en), .b_gpio(cfg_b_gpio), .hit(hit)
  );

  assign start_warm = (state == ST_SLEEP) && (|hit);

  pdw_settle #(.CNT_W(CNT_W)) u_settle (
    .clk(clk), .rst(rst), .load(start_warm), .load_val(settle_cfg),
    .run(state == ST_WARM), .done(settle_done)
  );

  always_comb begin
    nxt = state;
    unique case (state)
      ST_RUN:   if (pctl_we && pctl_pd_bit) nxt = ST_SLEEP;
      ST_SLEEP: if (|hit) nxt = ST_WARM;
      ST_WARM:  if (settle_done && pll_lock) nxt = ST_RUN;
      default:  nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_RUN;
      osc_en    <= 1'b1;
      pll_en    <= 1'b1;
      clk_en    <= 1'b1;
      wake_irq  <= 1'b0;
      wake_stat <= '0;
    end else begin
      state     <= nxt;
      osc_en    <= (nxt != ST_SLEEP);
      pll_en    <= (nxt != ST_SLEEP);
      clk_en    <= (nxt == ST_RUN);
      wake_irq  <= (state == ST_WARM) && (nxt == ST_RUN);
      wake_stat <= (wake_stat & ~stat_clr) | (start_warm ? hit : '0);
    end
  end
endmodule

// File: rtl/pdwake_ctrl_chk.sv
module pdwake_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       pctl_we,
  input logic       pctl_pd_bit,
  input logic       pll_lock,
  input logic       osc_en,
  input logic       clk_en,
  input logic       wake_irq,
  input logic [2:0] wake_stat,
  input logic [2:0] stat_clr
);
  a_r2_sleep_entry: assert property (@(posedge clk) disable iff (rst)
    (clk_en && pctl_we && pctl_pd_bit) |=> (!clk_en && !osc_en));

  a_r5_irq_single: assert property (@(posedge clk) disable iff (rst)
    wake_irq |=> !wake_irq);

  a_r5_irq_with_clk: assert property (@(posedge clk) disable iff (rst)
    wake_irq |-> (clk_en && !$past(clk_en)));

  a_r4_clk_needs_osc: assert property (@(posedge clk) disable iff (rst)
    clk_en |-> osc_en);

  a_r4_lock_seen: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_en) |-> $past(pll_lock));

  a_r10_stat_quiet_run: assert property (@(posedge clk) disable iff (rst)
    (clk_en && stat_clr == 3'b000) |=> $stable(wake_stat));
endmodule

bind pdwake_ctrl pdwake_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .pctl_we(pctl_we), .pctl_pd_bit(pctl_pd_bit),
  .pll_lock(pll_lock), .osc_en(osc_en), .clk_en(clk_en),
  .wake_irq(wake_irq), .wake_stat(wake_stat), .stat_clr(stat_clr)
);

// File: tb/tb_pdwake_ctrl.sv
`timescale 1ns/1ps
module tb_pdwake_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pctl_we = 0, pctl_pd_bit = 0;
  logic       wk_pin_a = 1, wk_pin_b = 1, bus_act = 0, pll_lock = 1;
  logic       cfg_pol_a = 0, cfg_pol_b = 0, cfg_b_gpio = 0;
  logic [2:0] cfg_en = 3'b111;
  logic [7:0] settle_cfg = 8'd4;
  logic [2:0] stat_clr = 3'b000;
  logic       osc_en, pll_en, clk_en, wake_irq;
  logic [2:0] wake_stat;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  pdwake_ctrl dut (
    .clk(clk), .rst(rst), .pctl_we(pctl_we), .pctl_pd_bit(pctl_pd_bit),
    .wk_pin_a(wk_pin_a), .wk_pin_b(wk_pin_b), .bus_act(bus_act),
    .pll_lock(pll_lock), .cfg_pol_a(cfg_pol_a), .cfg_pol_b(cfg_pol_b),
    .cfg_b_gpio(cfg_b_gpio), .cfg_en(cfg_en), .settle_cfg(settle_cfg),
    .stat_clr(stat_clr), .osc_en(osc_en), .pll_en(pll_en), .clk_en(clk_en),
    .wake_irq(wake_irq), .wake_stat(wake_stat)
  );

  // {pol_a, pol_b, gpio, en[2:0], act[2:0] (0 bus,1 A,2 B), exp_stat[2:0]}
  localparam int NV = 8;
  localparam logic [11:0] VEC [NV] = '{
    {3'b000, 3'b111, 3'b010, 3'b010},
    {3'b100, 3'b111, 3'b010, 3'b010},
    {3'b010, 3'b111, 3'b100, 3'b100},
    {3'b001, 3'b111, 3'b100, 3'b000},
    {3'b000, 3'b101, 3'b010, 3'b000},
    {3'b000, 3'b111, 3'b001, 3'b001},
    {3'b000, 3'b111, 3'b011, 3'b011},
    {3'b000, 3'b111, 3'b100, 3'b100}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle_pins();
    wk_pin_a = ~cfg_pol_a;
    wk_pin_b = ~cfg_pol_b;
    bus_act  = 1'b0;
  endtask

  task automatic enter_sleep();
    @(negedge clk);
    idle_pins();
    repeat (3) @(negedge clk);
    pctl_we = 1; pctl_pd_bit = 1;
    @(negedge clk);
    pctl_we = 0; pctl_pd_bit = 0;
    check("R2 clocks off", {osc_en, pll_en, clk_en}, 3'b000);
  endtask

  task automatic clear_stat();
    stat_clr = 3'b111;
    @(negedge clk);
    stat_clr = 3'b000;
  endtask

  task automatic recover();
    cfg_en = 3'b001; bus_act = 1;
    for (int k = 0; k < 300 && !clk_en; k++) @(negedge clk);
    bus_act = 0;
    clear_stat();
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 enables", {osc_en, pll_en, clk_en}, 3'b111);
    check("R1 irq", wake_irq, 0);
    check("R1 stat", wake_stat, 0);

    // R2 write with bit0 = 0 is ignored
    pctl_we = 1; pctl_pd_bit = 0;
    @(negedge clk);
    pctl_we = 0;
    @(negedge clk);
    check("R2 pd=0 ignored", {osc_en, clk_en}, 2'b11);

    // vector table: polarity R6, gpio R7, enables R8, bus R11, status R9
    for (int v = 0; v < NV; v++) begin
      logic [11:0] e;
      logic        will_wake;
      e = VEC[v];
      cfg_pol_a = e[11]; cfg_pol_b = e[10]; cfg_b_gpio = e[9];
      cfg_en = e[8:6]; settle_cfg = 8'd4; pll_lock = 1;
      will_wake = (e[2:0] != 3'b000);
      enter_sleep();
      bus_act  = e[3];
      wk_pin_a = e[4] ? cfg_pol_a : ~cfg_pol_a;
      wk_pin_b = e[5] ? cfg_pol_b : ~cfg_pol_b;
      repeat (2) @(negedge clk);
      check("R3 no early restart", osc_en, 0);
      @(negedge clk);
      check("R6 R7 R8 R11 restart per vector", osc_en, will_wake);
      check("R3 clk still off", clk_en, 0);
      if (will_wake) begin
        check("R3 pll_en on", pll_en, 1);
        repeat (4) @(negedge clk);
        check("R4 clk held during settle", clk_en, 0);
        @(negedge clk);
        check("R4 clk back", clk_en, 1);
        check("R5 irq with clk", wake_irq, 1);
        check("R9 stat per vector", wake_stat, e[2:0]);
        @(negedge clk);
        check("R5 irq single", wake_irq, 0);
        idle_pins();
        clear_stat();
        check("R9 stat cleared", wake_stat, 0);
      end else begin
        repeat (8) @(negedge clk);
        check("R7 R8 still asleep", {osc_en, clk_en}, 2'b00);
        check("R7 R8 stat empty", wake_stat, 0);
        recover();
      end
    end

    // R4 lock held low, settle zero
    cfg_pol_a = 0; cfg_pol_b = 0; cfg_b_gpio = 0; cfg_en = 3'b111;
    settle_cfg = 8'd0; pll_lock = 0;
    enter_sleep();
    bus_act = 1;
    repeat (3) @(negedge clk);
    check("R3 restart settle0", osc_en, 1);
    repeat (6) @(negedge clk);
    check("R4 waits for lock", clk_en, 0);
    pll_lock = 1;
    @(negedge clk);
    check("R4 lock releases clk", clk_en, 1);
    check("R5 irq on lock", wake_irq, 1);
    bus_act = 0;

    // R9 partial clear: only cleared bit drops, others sticky
    stat_clr = 3'b010;
    @(negedge clk);
    stat_clr = 3'b000;
    check("R9 partial clear keeps bit0", wake_stat, 3'b001);
    repeat (3) @(negedge clk);
    check("R9 sticky", wake_stat, 3'b001);
    clear_stat();

    // R4 settle zero with lock high: clk on 4th edge after input
    enter_sleep();
    wk_pin_a = 0;
    repeat (3) @(negedge clk);
    check("R4 settle0 not yet", clk_en, 0);
    @(negedge clk);
    check("R4 settle0 clk back", clk_en, 1);
    idle_pins();
    clear_stat();

    // R10 wake inputs while running are ignored
    bus_act = 1; wk_pin_a = 0; wk_pin_b = 0;
    repeat (6) @(negedge clk);
    check("R10 clocks stay on", {osc_en, pll_en, clk_en}, 3'b111);
    check("R10 stat unchanged", wake_stat, 0);
    check("R10 no irq", wake_irq, 0);
    idle_pins();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule